// File: doc/BRIEF.md
# Rotating Priority Interrupt Resolver

This block picks one of eight interrupt lines for a processor. Each cycle it looks at the pending requests that are not masked, ranks them against a rotatable priority base, and compares the best one with the most urgent line already in service. If the pending line ranks strictly higher, the interrupt output rises. The block holds the in-service register and the rotation base itself. Outside logic holds the request register and decodes the commands. It reaches this block through plain control pins: a set of in-service bits to clear, and a base load.

An acknowledge strobe moves the winning line into service. One cycle later it produces an 8-bit vector: five programmed upper bits over the 3-bit line number. With nothing to grant, the strobe yields the spurious code, line 7. A poll strobe yields a status byte in place of a vector. It also retires the winner's in-service bit without setting it. On either strobe, a one-hot clear pulse in the same cycle tells the request holder which request bit to drop.

Both result outputs (vector and poll byte) are valid-only streams. Each is a one-cycle valid pulse with its data held until the next strobe of the same kind. There is no ready and no back-pressure: the acknowledging side must take the data in the cycle that valid is high.

Top module: `pic_prio_core`

## Requirements
- R1: During and right after reset (active-low `rst_n`), the outputs read as follows: `isr_o` is 0, `base_o` is 0, `vec_vld_o` and `poll_vld_o` are 0, and `int_o` is 0 while no request is present.
- R2: The candidates are `req_i & ~mask_i`. Line L has rank (L - `base_o`) mod 8, rank 0 is the most urgent, and the candidate with the lowest rank wins.
- R3: `int_o` is high, combinationally, exactly when the winner's rank is strictly below the lowest rank among the `isr_o` bits (8 when there are none). When `sfnm_i` and `primary_i` are both 1, `isr_o` bit 2 is left out of that in-service rank.
- R4: An `ack_i` while `int_o` is high sets the winner's bit in `isr_o` at the next edge. In the next cycle `vec_vld_o` is 1 and `vec_o` = {`vbase_i`, line[2:0]}. `vec_vld_o` is 1 exactly in the cycle after each `ack_i`.
- R5: An `ack_i` while `int_o` is low gives `vec_o` = {`vbase_i`, 3'b111} and leaves `isr_o` unchanged apart from `eoi_clr_i`.
- R6: With `aeoi_i` = 1, a granted acknowledge leaves the winner's `isr_o` bit clear. If `rot_aeoi_i` is also 1, `base_o` becomes (line + 1) mod 8.
- R7: Bits set in `eoi_clr_i` clear the matching `isr_o` bits at the next edge, and `base_wr_i` loads `base_wr_val_i` into `base_o`. An acknowledge setting the same `isr_o` bit wins over the clear, and an auto-EOI rotation wins over the base load.
- R8: A `poll_i` (with `ack_i` low) gives, in the next cycle, `poll_vld_o` = 1 and `poll_o` = 8'h80 | line when `int_o` was high, with that line's `isr_o` bit cleared. Otherwise `poll_o` is 8'h07.
- R9: In the cycle of a granted strobe, `req_clr_o` is the one-hot bit of the winning line. On an acknowledge, lines marked level-sensitive in `level_i` are left out. A granted poll always gives the bit. `req_clr_o` is 0 in every other cycle.
- R10: When `ack_i` and `poll_i` are high together, the acknowledge is served and the poll is ignored: `poll_vld_o` stays 0 and `poll_o` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 8 | Pending request bits |
| mask_i | input | 8 | Mask bits, 1 blocks the line |
| level_i | input | 8 | 1 marks a level-sensitive line, whose request is not cleared on acknowledge |
| vbase_i | input | 5 | Upper five bits of the vector |
| aeoi_i | input | 1 | Auto end-of-interrupt mode |
| rot_aeoi_i | input | 1 | Rotate the base on auto end-of-interrupt |
| sfnm_i | input | 1 | Special fully nested mode |
| primary_i | input | 1 | This instance is the primary of a cascade |
| ack_i | input | 1 | Acknowledge strobe |
| poll_i | input | 1 | Poll strobe |
| eoi_clr_i | input | 8 | In-service bits to clear |
| base_wr_i | input | 1 | Load the rotation base |
| base_wr_val_i | input | 3 | Value for the base load |
| int_o | output | 1 | Interrupt output to the processor |
| req_clr_o | output | 8 | One-hot request clear pulse |
| vec_vld_o | output | 1 | Vector valid pulse |
| vec_o | output | 8 | Interrupt vector |
| poll_vld_o | output | 1 | Poll result valid pulse |
| poll_o | output | 8 | Poll status byte |
| isr_o | output | 8 | In-service register |
| base_o | output | 3 | Rotation base |

## Verification
A wrong in-service bit or a drifted base can be seen in two ways. It shows directly on `isr_o` or `base_o` one edge after the faulty update. It shows indirectly on `int_o` in the same cycle, because the resolver is combinational, so a misranked candidate either raises the line too early or holds it low. A wrong winner selection shows in the cycle of the strobe on `req_clr_o` and one cycle later in `vec_o` or `poll_o`. The model is therefore compared on every output every cycle. It runs under all sixteen combinations of the mode pins, with random rotation bases, masks and level-sensitive lines.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int LINES  = 8;
  localparam int IDX_W  = $clog2(LINES);
  localparam int RANK_W = IDX_W + 1;
  localparam int VEC_W  = 8;
  localparam int VBASE_W = VEC_W - IDX_W;
  localparam logic [RANK_W-1:0] RANK_NONE = RANK_W'(LINES);
  localparam int CASCADE_LINE = 2;

  typedef logic [LINES-1:0]  line_vec_t;
  typedef logic [IDX_W-1:0]  line_idx_t;
  typedef logic [RANK_W-1:0] rank_t;
endpackage

// File: rtl/pic_rank_find.sv
module pic_rank_find
  import pic_pkg::*;
#(
  parameter int N = LINES
) (
  input  logic [N-1:0]         vec_i,
  input  logic [$clog2(N)-1:0] base_i,
  output logic [$clog2(N):0]   rank_o,
  output logic                 hit_o
);
  localparam int IW = $clog2(N);
  localparam int RW = IW + 1;

  logic [2*N-1:0] dbl;
  logic [N-1:0]   rot;

  // rot[r] is the line whose rank is r
  always_comb begin
    dbl = {vec_i, vec_i};
    rot = dbl[base_i +: N];
  end

  always_comb begin
    rank_o = RW'(N);
    for (int i = N - 1; i >= 0; i--) begin
      if (rot[i]) rank_o = RW'(i);
    end
  end

  assign hit_o = |vec_i;
endmodule

// File: rtl/pic_resolve.sv
module pic_resolve
  import pic_pkg::*;
(
  input  line_vec_t req_i,
  input  line_vec_t mask_i,
  input  line_vec_t isr_i,
  input  line_idx_t base_i,
  input  logic      sfnm_i,
  input  logic      primary_i,
  output logic      grant_o,
  output line_idx_t line_o
);
  line_vec_t cand;
  line_vec_t isr_eff;
  rank_t     cand_rank;
  rank_t     srv_rank;
  logic      cand_hit;
  logic      srv_hit;

  assign cand = req_i & ~mask_i;

  always_comb begin
    isr_eff = isr_i;
    if (sfnm_i && primary_i) isr_eff[CASCADE_LINE] = 1'b0;
  end

  pic_rank_find #(.N(LINES)) u_cand_rank (
    .vec_i (cand),
    .base_i(base_i),
    .rank_o(cand_rank),
    .hit_o (cand_hit)
  );

  pic_rank_find #(.N(LINES)) u_srv_rank (
    .vec_i (isr_eff),
    .base_i(base_i),
    .rank_o(srv_rank),
    .hit_o (srv_hit)
  );

  // no in-service bit gives RANK_NONE, which any candidate beats
  always_comb begin
    grant_o = cand_hit && (srv_hit ? (cand_rank < srv_rank) : 1'b1);
    line_o  = IDX_W'(cand_rank[IDX_W-1:0] + base_i);
  end
endmodule

// File: rtl/pic_service.sv
module pic_service
  import pic_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ack_i,
  input  logic                poll_i,
  input  logic                grant_i,
  input  line_idx_t           line_i,
  input  line_vec_t           level_i,
  input  logic [VBASE_W-1:0]  vbase_i,
  input  logic                aeoi_i,
  input  logic                rot_aeoi_i,
  input  line_vec_t           eoi_clr_i,
  input  logic                base_wr_i,
  input  line_idx_t           base_wr_val_i,
  output line_vec_t           req_clr_o,
  output logic                vec_vld_o,
  output logic [VEC_W-1:0]    vec_o,
  output logic                poll_vld_o,
  output logic [VEC_W-1:0]    poll_o,
  output line_vec_t           isr_o,
  output line_idx_t           base_o
);
  localparam line_idx_t SPUR_LINE = line_idx_t'(LINES - 1);

  line_vec_t          isr_q, isr_n;
  line_idx_t          base_q, base_n;
  logic               vvld_q, pvld_q;
  logic [VEC_W-1:0]   vec_q, vec_n, poll_q, poll_n;
  line_vec_t          win_oh;
  logic               poll_take;
  logic               ack_grant, poll_grant;

  assign win_oh     = line_vec_t'(1) << line_i;
  assign poll_take  = poll_i && !ack_i;
  assign ack_grant  = ack_i && grant_i;
  assign poll_grant = poll_take && grant_i;

  always_comb begin
    req_clr_o = '0;
    if (ack_grant)       req_clr_o = win_oh & ~level_i;
    else if (poll_grant) req_clr_o = win_oh;
  end

  always_comb begin
    isr_n = isr_q & ~eoi_clr_i;
    if (ack_grant && !aeoi_i) isr_n = isr_n | win_oh;
    if (poll_grant)           isr_n = isr_n & ~win_oh;
  end

  always_comb begin
    base_n = base_wr_i ? base_wr_val_i : base_q;
    if (ack_grant && aeoi_i && rot_aeoi_i) base_n = line_i + 1'b1;
  end

  always_comb begin
    vec_n = vec_q;
    if (ack_i) vec_n = {vbase_i, grant_i ? line_i : SPUR_LINE};
  end

  always_comb begin
    poll_n = poll_q;
    if (poll_take) begin
      if (grant_i) poll_n = {1'b1, {(VEC_W-1-IDX_W){1'b0}}, line_i};
      else         poll_n = VEC_W'(SPUR_LINE);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr_q  <= '0;
      base_q <= '0;
      vvld_q <= 1'b0;
      pvld_q <= 1'b0;
      vec_q  <= '0;
      poll_q <= '0;
    end else begin
      isr_q  <= isr_n;
      base_q <= base_n;
      vvld_q <= ack_i;
      pvld_q <= poll_take;
      vec_q  <= vec_n;
      poll_q <= poll_n;
    end
  end

  assign vec_vld_o  = vvld_q;
  assign vec_o      = vec_q;
  assign poll_vld_o = pvld_q;
  assign poll_o     = poll_q;
  assign isr_o      = isr_q;
  assign base_o     = base_q;
endmodule

// File: rtl/pic_prio_core.sv
module pic_prio_core
  import pic_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  req_i,
  input  logic [7:0]  mask_i,
  input  logic [7:0]  level_i,
  input  logic [4:0]  vbase_i,
  input  logic        aeoi_i,
  input  logic        rot_aeoi_i,
  input  logic        sfnm_i,
  input  logic        primary_i,
  input  logic        ack_i,
  input  logic        poll_i,
  input  logic [7:0]  eoi_clr_i,
  input  logic        base_wr_i,
  input  logic [2:0]  base_wr_val_i,
  output logic        int_o,
  output logic [7:0]  req_clr_o,
  output logic        vec_vld_o,
  output logic [7:0]  vec_o,
  output logic        poll_vld_o,
  output logic [7:0]  poll_o,
  output logic [7:0]  isr_o,
  output logic [2:0]  base_o
);
  logic      grant;
  line_idx_t line;
  line_vec_t isr_w;
  line_idx_t base_w;

  pic_resolve u_resolve (
    .req_i    (req_i),
    .mask_i   (mask_i),
    .isr_i    (isr_w),
    .base_i   (base_w),
    .sfnm_i   (sfnm_i),
    .primary_i(primary_i),
    .grant_o  (grant),
    .line_o   (line)
  );

  pic_service u_service (
    .clk          (clk),
    .rst_n        (rst_n),
    .ack_i        (ack_i),
    .poll_i       (poll_i),
    .grant_i      (grant),
    .line_i       (line),
    .level_i      (level_i),
    .vbase_i      (vbase_i),
    .aeoi_i       (aeoi_i),
    .rot_aeoi_i   (rot_aeoi_i),
    .eoi_clr_i    (eoi_clr_i),
    .base_wr_i    (base_wr_i),
    .base_wr_val_i(base_wr_val_i),
    .req_clr_o    (req_clr_o),
    .vec_vld_o    (vec_vld_o),
    .vec_o        (vec_o),
    .poll_vld_o   (poll_vld_o),
    .poll_o       (poll_o),
    .isr_o        (isr_w),
    .base_o       (base_w)
  );

  assign int_o  = grant;
  assign isr_o  = isr_w;
  assign base_o = base_w;
endmodule

// File: rtl/pic_prio_chk.sv
module pic_prio_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] req_i,
  input logic [7:0] mask_i,
  input logic       aeoi_i,
  input logic       ack_i,
  input logic       poll_i,
  input logic [7:0] eoi_clr_i,
  input logic       int_o,
  input logic [7:0] req_clr_o,
  input logic       vec_vld_o,
  input logic       poll_vld_o,
  input logic [7:0] poll_o,
  input logic [7:0] isr_o
);
  AST_CLR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_clr_o)); // R9

  AST_CLR_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_i && !poll_i) |-> (req_clr_o == 8'h00)); // R9

  AST_VEC_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ack_i |=> vec_vld_o); // R4

  AST_VEC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_i |=> !vec_vld_o); // R4

  AST_ACK_OVER_POLL: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && poll_i) |=> (!poll_vld_o && $stable(poll_o))); // R10

  AST_AEOI_KEEPS_ISR: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && aeoi_i && eoi_clr_i == 8'h00) |=> (isr_o == $past(isr_o))); // R6

  AST_POLL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    poll_vld_o |-> (poll_o[6:3] == 4'h0 && (poll_o[7] || poll_o[2:0] == 3'd7))); // R8

  AST_INT_NEEDS_CAND: assert property (@(posedge clk) disable iff (!rst_n)
    int_o |-> ((req_i & ~mask_i) != 8'h00)); // R3
endmodule

bind pic_prio_core pic_prio_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_i     (req_i),
  .mask_i    (mask_i),
  .aeoi_i    (aeoi_i),
  .ack_i     (ack_i),
  .poll_i    (poll_i),
  .eoi_clr_i (eoi_clr_i),
  .int_o     (int_o),
  .req_clr_o (req_clr_o),
  .vec_vld_o (vec_vld_o),
  .poll_vld_o(poll_vld_o),
  .poll_o    (poll_o),
  .isr_o     (isr_o)
);

// File: tb/pic_prio_core_tb_top.sv
module pic_prio_core_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n;
  logic [7:0] req_i, mask_i, level_i, eoi_clr_i;
  logic [4:0] vbase_i;
  logic       aeoi_i, rot_aeoi_i, sfnm_i, primary_i, ack_i, poll_i, base_wr_i;
  logic [2:0] base_wr_val_i;
  logic       int_o, vec_vld_o, poll_vld_o;
  logic [7:0] req_clr_o, vec_o, poll_o, isr_o;
  logic [2:0] base_o;

  pic_prio_core dut_i (.*);

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  bit [7:0] m_req, m_isr, m_vec, m_poll;
  bit [2:0] m_base;
  bit       m_vv, m_pv;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int min_rank(bit [7:0] v, bit [2:0] b);
    for (int r = 0; r < 8; r++)
      if (v[(b + r) % 8]) return r;
    return 8;
  endfunction

  // one clock cycle: inputs other than req_i already set at a falling edge
  task automatic cycle();
    bit [7:0] eff, clr, isr_nx;
    bit [2:0] base_nx, ln;
    bit       g, pt;
    int       cr, sr;
    req_i = m_req;
    #1;
    eff = m_isr;
    if (sfnm_i && primary_i) eff[2] = 1'b0;
    cr = min_rank(m_req & ~mask_i, m_base);
    sr = min_rank(eff, m_base);
    g  = (cr < sr);
    ln = 3'((m_base + cr) % 8);
    pt = poll_i && !ack_i;
    clr = 8'h00;
    if (ack_i && g)   clr = (8'h01 << ln) & ~level_i;
    else if (pt && g) clr = 8'h01 << ln;

    chk("R2/R3 int_o", int_o, g);
    chk("R9 req_clr_o", req_clr_o, clr);
    chk("R4/R6/R7 isr_o", isr_o, m_isr);
    chk("R6/R7 base_o", base_o, m_base);
    chk("R4 vec_vld_o", vec_vld_o, m_vv);
    if (m_vv) chk("R4/R5 vec_o", vec_o, m_vec);
    chk("R8/R10 poll_vld_o", poll_vld_o, m_pv);
    chk("R8/R10 poll_o", poll_o, m_poll);

    isr_nx = m_isr & ~eoi_clr_i;
    if (ack_i && g && !aeoi_i) isr_nx[ln] = 1'b1;
    if (pt && g) isr_nx[ln] = 1'b0;
    base_nx = base_wr_i ? base_wr_val_i : m_base;
    if (ack_i && g && aeoi_i && rot_aeoi_i) base_nx = ln + 3'd1;

    @(posedge clk);
    m_isr  = isr_nx;
    m_base = base_nx;
    m_vv   = ack_i;
    m_pv   = pt;
    if (ack_i) m_vec = {vbase_i, g ? ln : 3'd7};
    if (pt)    m_poll = g ? (8'h80 | 8'(ln)) : 8'h07;
    m_req  = m_req & ~clr;
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    ack_i = 0; poll_i = 0; eoi_clr_i = 0; base_wr_i = 0; base_wr_val_i = 0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0;
    m_req = 0; m_isr = 0; m_base = 0; m_vv = 0; m_pv = 0; m_vec = 0; m_poll = 0;
    req_i = 0; mask_i = 0; level_i = 0; vbase_i = 5'h01;
    aeoi_i = 0; rot_aeoi_i = 0; sfnm_i = 0; primary_i = 0;
    idle_inputs();
    repeat (3) @(negedge clk);
    chk("R1 reset isr_o", isr_o, 8'h00);
    chk("R1 reset base_o", base_o, 3'd0);
    chk("R1 reset vec_vld_o", vec_vld_o, 1'b0);
    chk("R1 reset poll_vld_o", poll_vld_o, 1'b0);
    chk("R1 reset int_o", int_o, 1'b0);
    rst_n = 1;

    // directed: spurious acknowledge (R5)
    ack_i = 1; cycle(); idle_inputs();
    chk("R5 spurious vector", vec_o, 8'h0F);
    // directed: empty poll (R8)
    poll_i = 1; cycle(); idle_inputs();
    chk("R8 empty poll", poll_o, 8'h07);
    // directed: lines 4 and 5 pending, base 0, line 4 wins (R2/R4)
    m_req = 8'h30; ack_i = 1; cycle(); idle_inputs();
    chk("R4 vector line 4", vec_o, 8'h0C);
    chk("R4 isr line 4", isr_o, 8'h10);
    req_i = m_req; #1;
    chk("R3 lower rank blocked", int_o, 1'b0);
    // directed: ack and poll together (R10)
    m_req = 8'h01; ack_i = 1; poll_i = 1; cycle(); idle_inputs();
    chk("R10 poll ignored", poll_vld_o, 1'b0);
    eoi_clr_i = 8'hFF; cycle(); idle_inputs();
    chk("R7 clear all", isr_o, 8'h00);

    // random phases over all mode combinations
    for (int p = 0; p < 16; p++) begin
      aeoi_i = p[0]; rot_aeoi_i = p[1]; sfnm_i = p[2]; primary_i = p[3];
      for (int c = 0; c < 250; c++) begin
        idle_inputs();
        if ($urandom_range(0, 3) == 0) m_req = m_req | 8'(1 << $urandom_range(0, 7));
        if ($urandom_range(0, 15) == 0) mask_i = 8'($urandom) & 8'($urandom);
        if ($urandom_range(0, 31) == 0) level_i = 8'($urandom) & 8'($urandom);
        if ($urandom_range(0, 31) == 0) vbase_i = 5'($urandom);
        ack_i  = ($urandom_range(0, 4) == 0);
        poll_i = ($urandom_range(0, 9) == 0);
        if ($urandom_range(0, 5) == 0) eoi_clr_i = 8'(1 << $urandom_range(0, 7));
        if ($urandom_range(0, 19) == 0) begin
          base_wr_i = 1; base_wr_val_i = 3'($urandom);
        end
        if ((level_i & m_req) != 0 && $urandom_range(0, 7) == 0) m_req = m_req & ~level_i;
        cycle();
      end
    end
    idle_inputs();
    cycle();

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule